// File: doc/BRIEF.md
# Serial Word Receiver for a Sign-Magnitude DAC

This block takes a serial audio stream made of a data line, a bit clock and a word clock, and turns each word into a code for a pair of complementary current-segment converters. The three serial lines are already synchronous to the system clock `clk`. The block finds their edges by sampling them, so the bit clock must stay at each level for at least two `clk` cycles. On each bit-clock rise, one data bit enters a shift register, most significant bit first. The register keeps only the most recent bits. When the word clock falls, the block takes the trailing bits of the selected length as a two's-complement word. It aligns the word to full width and, if selected, inverts its phase.

The captured word does not reach the outputs at once. The outputs change on the second bit-clock rise after the word-clock fall. They leave as a sign bit plus a magnitude, split over a positive path and a negative path. Only one path carries a non-zero value, so the code steps away from zero by the same amount in both directions. A small state machine orders this. In `ST_IDLE` no word is pending. A word-clock fall captures the word and enters `ST_WAIT1`. The first bit-clock rise moves it to `ST_WAIT2`. The second rise loads the outputs and returns to `ST_IDLE`. A new word-clock fall in either wait state captures again and re-enters `ST_WAIT1`.

Top module: `sdac_word_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dac_sign` is 0 and both magnitude outputs are 0.
- R2: On a bit-clock rise, the bit on `sdata` enters the shift register at the least significant end. Words arrive most significant bit first, in two's complement.
- R3: Any number of extra bits may come before a word. Only the trailing bits shifted in before the word-clock fall form the word.
- R4: The word is captured only on a falling edge of `wclk`. A stream with no such edge leaves the outputs unchanged.
- R5: The outputs change on the second bit-clock rise after the word-clock fall, and never on the first rise. They change only in a cycle that follows a bit-clock rise.
- R6: If the bit clock stops after the word-clock fall, the outputs hold their old value until two bit-clock rises have occurred.
- R7: With `len_full`=1, the word is the last 24 bits. With `len_full`=0, it is the last 20 bits, placed in bits 23..4 with bits 3..0 set to zero.
- R8: With `phase_norm`=0, the aligned 24-bit word is inverted bit by bit before encoding. With `phase_norm`=1, it passes unchanged.
- R9: The sign is bit 23 of the word. The magnitude is bits 22..0 when the sign is 0, and the complement of bits 22..0 when the sign is 1. So 0x7FFFFF gives sign 0 and magnitude 0x7FFFFF, 0x000000 gives sign 0 and magnitude 0, 0xFFFFFF gives sign 1 and magnitude 0, and 0x800000 gives sign 1 and magnitude 0x7FFFFF.
- R10: `dac_mag_pos` carries the magnitude when the sign is 0 and is 0 otherwise. `dac_mag_neg` carries the magnitude when the sign is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock, sampled by clk |
| wclk | input | 1 | Word clock; its falling edge captures the word |
| sdata | input | 1 | Serial data, most significant bit first |
| len_full | input | 1 | 1 selects 24-bit words, 0 selects 20-bit words |
| phase_norm | input | 1 | 1 selects normal phase, 0 selects inverted phase |
| dac_sign | output | 1 | Sign of the current code, 1 for negative |
| dac_mag_pos | output | 23 | Magnitude for the positive path |
| dac_mag_neg | output | 23 | Magnitude for the negative path |

## Verification
The bench builds the block with its default widths: a 24-bit word, a 20-bit short word and a 23-bit magnitude. These widths bring the exact full-scale and near-zero codes within reach. They also expose the four padding bits of the short mode, and how they interact with phase inversion. Each bit-clock phase lasts two system-clock cycles, so the bench can sample the outputs between the first and second bit-clock rise. This tells a one-rise delay apart from the required two-rise delay.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT1 = 2'd1,
        ST_WAIT2 = 2'd2
    } rx_state_t;

endpackage

// File: rtl/sdac_edge.sv
module sdac_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/sdac_fmt.sv
module sdac_fmt #(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 20
) (
    input  logic [WORD_W-1:0] raw,
    input  logic              len_full,
    input  logic              phase_norm,
    output logic [WORD_W-1:0] word
);
    localparam int PAD_W = WORD_W - SHORT_W;

    logic [WORD_W-1:0] short_word;
    logic [WORD_W-1:0] aligned;

    generate
        if (PAD_W > 0) begin : g_pad
            assign short_word = {raw[SHORT_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign short_word = raw;
        end
    endgenerate

    assign aligned = len_full ? raw : short_word;
    assign word    = phase_norm ? aligned : ~aligned;
endmodule

// File: rtl/sdac_signmag.sv
module sdac_signmag #(
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [WORD_W-2:0] mag
);
    assign sign = word[WORD_W-1];
    assign mag  = sign ? ~word[WORD_W-2:0] : word[WORD_W-2:0];
endmodule

// File: rtl/sdac_word_rx.sv
module sdac_word_rx
    import sdac_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 20,
    parameter int MAG_W   = WORD_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             wclk,
    input  logic             sdata,
    input  logic             len_full,
    input  logic             phase_norm,
    output logic             dac_sign,
    output logic [MAG_W-1:0] dac_mag_pos,
    output logic [MAG_W-1:0] dac_mag_neg
);
    rx_state_t state, state_nxt;

    logic              b_rise, b_fall_unused;
    logic              w_rise_unused, w_fall;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] fmt_word;
    logic [WORD_W-1:0] held_word;
    logic              sm_sign;
    logic [MAG_W-1:0]  sm_mag;
    logic              load_out;

    sdac_edge u_bedge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (bclk),
        .rise (b_rise),
        .fall (b_fall_unused)
    );

    sdac_edge u_wedge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (wclk),
        .rise (w_rise_unused),
        .fall (w_fall)
    );

    sdac_shift #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(b_rise),
        .din     (sdata),
        .q       (shreg)
    );

    sdac_fmt #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_fmt (
        .raw       (shreg),
        .len_full  (len_full),
        .phase_norm(phase_norm),
        .word      (fmt_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_word <= '0;
        else if (w_fall) held_word <= fmt_word;
    end

    sdac_signmag #(.WORD_W(WORD_W)) u_sm (
        .word(held_word),
        .sign(sm_sign),
        .mag (sm_mag)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions: a word-clock fall always restarts the wait
    always_comb begin
        state_nxt = state;
        load_out  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (w_fall) state_nxt = ST_WAIT1;
            end
            ST_WAIT1: begin
                if (w_fall)      state_nxt = ST_WAIT1;
                else if (b_rise) state_nxt = ST_WAIT2;
            end
            ST_WAIT2: begin
                if (w_fall) begin
                    state_nxt = ST_WAIT1;
                end else if (b_rise) begin
                    state_nxt = ST_IDLE;
                    load_out  = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_sign    <= 1'b0;
            dac_mag_pos <= '0;
            dac_mag_neg <= '0;
        end else if (load_out) begin
            dac_sign    <= sm_sign;
            dac_mag_pos <= sm_sign ? '0 : sm_mag;
            dac_mag_neg <= sm_sign ? sm_mag : '0;
        end
    end
endmodule

// File: rtl/sdac_word_rx_chk.sv
module sdac_word_rx_chk #(
    parameter int MAG_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk,
    input logic             dac_sign,
    input logic [MAG_W-1:0] dac_mag_pos,
    input logic [MAG_W-1:0] dac_mag_neg
);
    logic bclk_seen;
    logic out_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_seen <= 1'b1;
            out_valid <= 1'b0;
        end else begin
            bclk_seen <= bclk;
            out_valid <= 1'b1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!dac_sign && dac_mag_pos == '0 && dac_mag_neg == '0));

    a_r5_change_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !($stable(dac_sign) && $stable(dac_mag_pos) && $stable(dac_mag_neg)))
        |-> $past(bclk && !bclk_seen));

    a_r10_pos_path_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sign |-> dac_mag_pos == '0);

    a_r10_neg_path_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sign |-> dac_mag_neg == '0);
endmodule

bind sdac_word_rx sdac_word_rx_chk #(.MAG_W(MAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .dac_sign   (dac_sign),
    .dac_mag_pos(dac_mag_pos),
    .dac_mag_neg(dac_mag_neg)
);

// File: tb/sim_sdac_word_rx.sv
module sim_sdac_word_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        wclk = 1'b1;
    logic        sdata = 1'b0;
    logic        len_full = 1'b1;
    logic        phase_norm = 1'b1;
    logic        dac_sign;
    logic [22:0] dac_mag_pos;
    logic [22:0] dac_mag_neg;

    int checks = 0;
    int errors = 0;
    logic        e_sign = 1'b0;
    logic [22:0] e_pos = '0;
    logic [22:0] e_neg = '0;

    always #5 clk = ~clk;

    sdac_word_rx u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdata(sdata),
        .len_full(len_full), .phase_norm(phase_norm),
        .dac_sign(dac_sign), .dac_mag_pos(dac_mag_pos), .dac_mag_neg(dac_mag_neg)
    );

    task automatic check_out(input string req);
        checks++;
        if (dac_sign !== e_sign || dac_mag_pos !== e_pos || dac_mag_neg !== e_neg) begin
            errors++;
            $display("FAIL %s: got sign=%0b pos=%h neg=%h, expected sign=%0b pos=%h neg=%h",
                     req, dac_sign, dac_mag_pos, dac_mag_neg, e_sign, e_pos, e_neg);
        end
    endtask

    task automatic set_expect(input logic [23:0] raw, input logic full, input logic norm);
        logic [23:0] w;
        logic [22:0] m;
        w = full ? raw : {raw[19:0], 4'h0};
        if (!norm) w = ~w;
        m = w[23] ? ~w[22:0] : w[22:0];
        e_sign = w[23];
        e_pos  = w[23] ? 23'h0 : m;
        e_neg  = w[23] ? m : 23'h0;
    endtask

    task automatic clk_bit(input logic b);
        @(negedge clk); bclk = 1'b0; sdata = b;
        @(negedge clk); @(negedge clk); bclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic drop_wclk();
        @(negedge clk); bclk = 1'b0; wclk = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    // Full frame: leading bits, word, fall, two rises; checks delay and result
    task automatic frame(input logic [63:0] v, input int n, input logic [23:0] raw,
                         input logic full, input logic norm, input string req);
        len_full = full; phase_norm = norm;
        wclk = 1'b1;
        send_bits(v, n);
        drop_wclk();
        check_out({req, " before first rise (R5)"});
        clk_bit(1'b1);
        @(negedge clk);
        check_out({req, " after first rise (R5)"});
        wclk = 1'b1;
        clk_bit(1'b0);
        set_expect(raw, full, norm);
        check_out(req);
    endtask

    task automatic t_fullscale();
        frame(64'h7FFFFF, 24, 24'h7FFFFF, 1'b1, 1'b1, "R9 R10 +full scale");
        frame(64'h000000, 24, 24'h000000, 1'b1, 1'b1, "R9 zero");
        frame(64'hFFFFFF, 24, 24'hFFFFFF, 1'b1, 1'b1, "R9 one below zero");
        frame(64'h800000, 24, 24'h800000, 1'b1, 1'b1, "R9 R10 -full scale");
    endtask

    task automatic t_leading();
        frame(64'h2B_5A_3C_12_34_56, 48, 24'h123456, 1'b1, 1'b1, "R2 R3 leading bits");
        frame(64'h7_C3_A5_81, 27, 24'hC3A581, 1'b1, 1'b1, "R3 negative after extras");
    endtask

    task automatic t_short();
        frame(64'hF_ABCDE, 24, 24'hFABCDE, 1'b0, 1'b1, "R7 20-bit word");
        frame(64'h00012, 20, 24'h00012, 1'b0, 1'b1, "R7 20-bit small");
    endtask

    task automatic t_invert();
        frame(64'h123456, 24, 24'h123456, 1'b1, 1'b0, "R8 inverted");
        frame(64'h800000, 24, 24'h800000, 1'b1, 1'b0, "R8 inverted -full");
        frame(64'h00012, 20, 24'h00012, 1'b0, 1'b0, "R7 R8 short inverted");
    endtask

    task automatic t_stopped();
        len_full = 1'b1; phase_norm = 1'b1; wclk = 1'b1;
        send_bits(64'h654321, 24);
        drop_wclk();
        repeat (40) @(negedge clk);
        check_out("R6 stopped clock holds");
        clk_bit(1'b0);
        repeat (30) @(negedge clk);
        check_out("R6 one rise then stop holds");
        wclk = 1'b1;
        clk_bit(1'b0);
        set_expect(24'h654321, 1'b1, 1'b1);
        check_out("R6 update after second rise");
    endtask

    task automatic t_no_fall();
        wclk = 1'b1;
        send_bits(64'h0A0B0C0D0E, 40);
        @(negedge clk);
        check_out("R4 no word-clock fall, no change");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check_out("R1 reset state");
                rst_n = 1'b1;
                @(negedge clk);
                check_out("R1 after reset");
                t_fullscale();
                t_leading();
                t_short();
                t_invert();
                t_stopped();
                t_no_fall();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule